// File: doc/BRIEF.md
# Pipelined 16x16 Multiply-Accumulate Unit

This block is a multiply-accumulate engine that sits beside a processor's execute stage. Each accepted command carries two 32-bit register operands, an operation code, a long/word flag, a product shift selector and two half-word selects. Word operations pick the upper or lower 16 bits of each operand, multiply them signed or unsigned, optionally shift the product one bit, and add it to or subtract it from a 32-bit accumulator. Saturation is optional. Long operations form the low 32 bits of a 32x32 product by passing through the same 16x16 array three times.

The block holds three registers that software can reach through commands: the accumulator, an 8-bit status register and a 16-bit mask register. Commands enter over a valid/ready port. A command moves only on a cycle where `op_valid` and `op_ready` are both high. Results leave over a second valid/ready port. `res_data` stays fixed while `res_valid` is high and `res_ready` is low, and during that time the whole pipeline stalls and `op_ready` is low. Every command completes in issue order, so a load or read of the accumulator or status register always sees the effect of every command accepted before it.

Top module: `mac16_unit`

## Requirements
- R1: Operation codes are 0 multiply-add, 1 multiply-subtract, 2 multiply (product to result port), 3 load accumulator, 4 load status, 5 load mask, 6 read accumulator, 7 read status, 8 read mask. A word multiply uses bits 31:16 of an operand when its half select is 1 and bits 15:0 otherwise. It is signed when status bit 4 is 0 and unsigned when status bit 4 is 1.
- R2: Code 0 adds the (shifted) product to the accumulator and code 1 subtracts it. Only codes 0, 1 and 3 change the accumulator.
- R3: With `op_shift` = 1, the product is shifted left one bit and a zero enters bit 0.
- R4: With `op_shift` = 2, the product is shifted right one bit. Bit 31 is filled with zero in unsigned mode and with the product's sign in signed word mode. Values 0 and 3 leave the product unshifted.
- R5: For a signed long right shift, the sign is shifted in unless the product is zero or overflowed, in which case a zero is shifted in. A long product overflows when both operands are nonzero and bit 31 of the 32-bit product differs from the XOR of the operand sign bits. Such an overflow also sets the status overflow flag.
- R6: A long operation (`op_long` = 1 with codes 0 to 2) yields the low 32 bits of the 32x32 product. After accepting one, `op_ready` is low for the next two cycles.
- R7: When status bit 6 is set, an accumulate that overflows clamps the accumulator. In signed mode it clamps to 0x7FFFFFFF or 0x80000000; in unsigned mode it clamps to 0xFFFFFFFF on add and to 0 on subtract. When status bit 6 is clear, the accumulator wraps.
- R8: Every accumulate sets status bit 2 (negative) from accumulator bit 31 and status bit 1 (zero) from an all-zero accumulator. Status bit 0 (overflow) is sticky until code 4 rewrites it. Code 4 writes only bits 0, 1, 2, 4 and 6.
- R9: Code 5 keeps only bits 15:0 of `op_a`, and code 8 returns them zero-extended.
- R10: Commands complete in issue order. A result appears on `res_valid` three cycles after the accepting edge. A command following a status load waits until that load has retired.
- R11: While `res_valid` is high and `res_ready` is low, `res_data` holds, `op_ready` is low and no state changes.
- R12: After reset the accumulator, status and mask read as zero, `res_valid` is low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command present |
| op_ready | output | 1 | Command accepted this cycle if valid |
| op_code | input | 4 | Operation code |
| op_long | input | 1 | 32x32 operation for multiply codes |
| op_shift | input | 2 | Product shift: 1 left, 2 right |
| op_hi_a | input | 1 | Word select for operand A |
| op_hi_b | input | 1 | Word select for operand B |
| op_a | input | 32 | Operand A / load value |
| op_b | input | 32 | Operand B |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Product or register read value |

## Verification
The assertions assume that `op_code` holds only the nine defined codes and that `op_long` is set only with the multiply codes. They also assume that all inputs are known after reset. The stimulus keeps to this. It drives only listed codes. It holds each command until it is accepted and drops `op_valid` on the cycle after the accepting edge. It changes `res_ready` only between clock edges. Stalls are created only by deasserting `res_ready`. The bench never attempts a command while a status load is in flight, other than by waiting on `op_ready`.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
  localparam int unsigned MAC_DW = 32;
  localparam int unsigned MAC_HW = MAC_DW / 2;
  localparam int unsigned SR_W   = 8;
  // status bit positions
  localparam int unsigned SR_V   = 0;
  localparam int unsigned SR_Z   = 1;
  localparam int unsigned SR_N   = 2;
  localparam int unsigned SR_US  = 4;
  localparam int unsigned SR_SAT = 6;
  localparam logic [SR_W-1:0] SR_WMASK = 8'h57;

  typedef enum logic [3:0] {
    OP_MAC    = 4'd0,
    OP_MSAC   = 4'd1,
    OP_MUL    = 4'd2,
    OP_LDACC  = 4'd3,
    OP_LDSR   = 4'd4,
    OP_LDMASK = 4'd5,
    OP_RDACC  = 4'd6,
    OP_RDSR   = 4'd7,
    OP_RDMASK = 4'd8
  } mac_op_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_LEFT  = 2'd1,
    SH_RIGHT = 2'd2,
    SH_KEEP  = 2'd3
  } shift_e;

  typedef struct packed {
    logic              vld;
    mac_op_e           op;
    shift_e            sh;
    logic              sgn;
    logic              lovf;
    logic [MAC_DW-1:0] val;
  } stage_t;

  function automatic logic is_acc_op(mac_op_e o);
    return (o == OP_MAC) || (o == OP_MSAC);
  endfunction

  function automatic logic is_mul_op(mac_op_e o);
    return (o == OP_MAC) || (o == OP_MSAC) || (o == OP_MUL);
  endfunction
endpackage

// File: rtl/mac16_array.sv
module mac16_array #(
  parameter int unsigned HW = 16
) (
  input  logic [HW-1:0]   x,
  input  logic [HW-1:0]   y,
  input  logic            sgn,
  output logic [2*HW-1:0] p
);
  logic signed [HW:0]     xe, ye;
  logic signed [2*HW+1:0] full;

  always_comb begin
    xe   = {sgn & x[HW-1], x};
    ye   = {sgn & y[HW-1], y};
    full = xe * ye;
    p    = full[2*HW-1:0];
  end
endmodule

// File: rtl/mac16_shift.sv
module mac16_shift import mac16_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] p,
  input  shift_e        sh,
  input  logic          sgn,
  input  logic          lovf,
  output logic [DW-1:0] q
);
  logic fill;

  always_comb begin
    fill = sgn & p[DW-1] & (|p) & ~lovf;
    unique case (sh)
      SH_LEFT:  q = {p[DW-2:0], 1'b0};
      SH_RIGHT: q = {fill, p[DW-1:1]};
      default:  q = p;
    endcase
  end
endmodule

// File: rtl/mac16_accum.sv
module mac16_accum #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] prod,
  input  logic          sub,
  input  logic          sgn,
  input  logic          sat,
  output logic [DW-1:0] nxt,
  output logic          ovf
);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  logic [DW:0]   ea, ep, sum;
  logic [DW-1:0] clamp;

  always_comb begin
    ea  = {sgn & acc[DW-1], acc};
    ep  = {sgn & prod[DW-1], prod};
    sum = sub ? (ea - ep) : (ea + ep);
    ovf = sgn ? (sum[DW] != sum[DW-1]) : sum[DW];
    if (sgn) clamp = sum[DW] ? SMIN : SMAX;
    else     clamp = sub ? '0 : '1;
    nxt = (ovf && sat) ? clamp : sum[DW-1:0];
  end
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit import mac16_pkg::*; #(
  parameter int unsigned DW = MAC_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [3:0]    op_code,
  input  logic          op_long,
  input  logic [1:0]    op_shift,
  input  logic          op_hi_a,
  input  logic          op_hi_b,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data
);
  localparam int unsigned HW = DW / 2;
  localparam logic [1:0]  LAST_PH = 2'd2;

  mac_op_e in_op;
  logic    advance, sr_busy, s1_hold, fire;

  // stage 1: operand select and array
  logic          s1_vld, s1_long, s1_hi_a, s1_hi_b;
  mac_op_e       s1_op;
  shift_e        s1_sh;
  logic [DW-1:0] s1_a, s1_b, lsum, lsum_nxt, s1_prod, arr_p;
  logic [1:0]    s1_phase;
  logic [HW-1:0] mx, my;
  logic          arr_sgn, s1_sgn, s1_lovf;

  stage_t        s2, s3;
  logic [DW-1:0] shifted, acc_q, acc_nxt, rd_val;
  logic          acc_ovf;
  logic [SR_W-1:0] sr_q;
  logic [HW-1:0] mask_q;
  shift_e        s2_sh_eff;

  assign in_op    = mac_op_e'(op_code);
  assign advance  = !res_valid || res_ready;
  assign sr_busy  = (s1_vld && s1_op == OP_LDSR) || (s2.vld && s2.op == OP_LDSR) ||
                    (s3.vld && s3.op == OP_LDSR);
  assign s1_hold  = s1_vld && s1_long && (s1_phase != LAST_PH);
  assign op_ready = advance && !sr_busy && !s1_hold;
  assign fire     = op_valid && op_ready;

  always_comb begin
    if (s1_long) begin
      unique case (s1_phase)
        2'd0:    begin mx = s1_a[HW-1:0];  my = s1_b[HW-1:0];  end
        2'd1:    begin mx = s1_a[DW-1:HW]; my = s1_b[HW-1:0];  end
        default: begin mx = s1_a[HW-1:0];  my = s1_b[DW-1:HW]; end
      endcase
    end else begin
      mx = s1_hi_a ? s1_a[DW-1:HW] : s1_a[HW-1:0];
      my = s1_hi_b ? s1_b[DW-1:HW] : s1_b[HW-1:0];
    end
    s1_sgn   = !sr_q[SR_US];
    arr_sgn  = !s1_long && s1_sgn;
    lsum_nxt = (s1_phase == 2'd0) ? arr_p : lsum + {arr_p[HW-1:0], {HW{1'b0}}};
    s1_prod  = s1_long ? lsum_nxt : arr_p;
    s1_lovf  = s1_long && s1_sgn && (|s1_a) && (|s1_b) &&
               (s1_prod[DW-1] != (s1_a[DW-1] ^ s1_b[DW-1]));
  end

  mac16_array #(.HW(HW)) u_array (.x(mx), .y(my), .sgn(arr_sgn), .p(arr_p));

  assign s2_sh_eff = is_acc_op(s2.op) ? s2.sh : SH_NONE;

  mac16_shift #(.DW(DW)) u_shift (
    .p(s2.val), .sh(s2_sh_eff), .sgn(s2.sgn), .lovf(s2.lovf), .q(shifted)
  );

  mac16_accum #(.DW(DW)) u_accum (
    .acc(acc_q), .prod(s3.val), .sub(s3.op == OP_MSAC), .sgn(s3.sgn),
    .sat(sr_q[SR_SAT]), .nxt(acc_nxt), .ovf(acc_ovf)
  );

  always_comb begin
    unique case (s3.op)
      OP_MUL:    rd_val = s3.val;
      OP_RDACC:  rd_val = acc_q;
      OP_RDSR:   rd_val = {{(DW-SR_W){1'b0}}, sr_q};
      OP_RDMASK: rd_val = {{(DW-HW){1'b0}}, mask_q};
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_long <= 1'b0; s1_hi_a <= 1'b0; s1_hi_b <= 1'b0;
      s1_op <= OP_MAC; s1_sh <= SH_NONE; s1_a <= '0; s1_b <= '0;
      s1_phase <= 2'd0; lsum <= '0;
      s2 <= '0; s3 <= '0;
      acc_q <= '0; sr_q <= '0; mask_q <= '0;
      res_valid <= 1'b0; res_data <= '0;
    end else if (advance) begin
      // stage 1
      if (fire) begin
        s1_vld   <= 1'b1;
        s1_op    <= in_op;
        s1_long  <= op_long && is_mul_op(in_op);
        s1_sh    <= shift_e'(op_shift);
        s1_hi_a  <= op_hi_a;
        s1_hi_b  <= op_hi_b;
        s1_a     <= op_a;
        s1_b     <= op_b;
        s1_phase <= 2'd0;
      end else if (s1_hold) begin
        s1_phase <= s1_phase + 2'd1;
        lsum     <= lsum_nxt;
      end else begin
        s1_vld   <= 1'b0;
      end
      // stage 2
      s2.vld  <= s1_vld && !s1_hold;
      s2.op   <= s1_op;
      s2.sh   <= s1_sh;
      s2.sgn  <= s1_sgn;
      s2.lovf <= s1_lovf;
      s2.val  <= is_mul_op(s1_op) ? s1_prod : s1_a;
      // stage 3
      s3     <= s2;
      s3.val <= shifted;
      // retire
      res_valid <= s3.vld && (s3.op inside {OP_MUL, OP_RDACC, OP_RDSR, OP_RDMASK});
      res_data  <= rd_val;
      if (s3.vld) begin
        unique case (s3.op)
          OP_MAC, OP_MSAC: begin
            acc_q      <= acc_nxt;
            sr_q[SR_N] <= acc_nxt[DW-1];
            sr_q[SR_Z] <= (acc_nxt == '0);
            sr_q[SR_V] <= sr_q[SR_V] | acc_ovf | s3.lovf;
          end
          OP_LDACC:  acc_q  <= s3.val;
          OP_LDSR:   sr_q   <= s3.val[SR_W-1:0] & SR_WMASK;
          OP_LDMASK: mask_q <= s3.val[HW-1:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  logic s3_acc_wr, s3_sat_hit;
  assign s3_acc_wr  = advance && s3.vld && (is_acc_op(s3.op) || s3.op == OP_LDACC);
  assign s3_sat_hit = advance && s3.vld && is_acc_op(s3.op) && sr_q[SR_SAT] && acc_ovf;

  p_long_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_hold |-> !op_ready);

  p_acc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_acc_wr |=> $stable(acc_q));

  p_sat_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s3_sat_hit |=> (acc_q == {1'b0, {(DW-1){1'b1}}} || acc_q == {1'b1, {(DW-1){1'b0}}} ||
                    acc_q == '1 || acc_q == '0));

  p_sticky_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q[SR_V] && !(advance && s3.vld && s3.op == OP_LDSR)) |=> sr_q[SR_V]);

  p_res_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

  p_uns_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2.vld && is_acc_op(s2.op) && s2.sh == SH_RIGHT && !s2.sgn) |-> !shifted[DW-1]);
endmodule

// File: tb/mac16_unit_tb.sv
`timescale 1ns/1ps
module mac16_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [3:0]  op_code = 4'd0;
  logic        op_long = 1'b0;
  logic [1:0]  op_shift = 2'd0;
  logic        op_hi_a = 1'b0, op_hi_b = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_data;

  always #2.5 clk = ~clk;

  mac16_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_long(op_long), .op_shift(op_shift),
    .op_hi_a(op_hi_a), .op_hi_b(op_hi_b), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        lng;
    logic [1:0]  sh;
    logic        ha;
    logic        hb;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 59;
  localparam vec_t VEC [NV] = '{
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd12},           // R12 acc
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd12},           // R12 status
    '{4'd8, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd12},           // R12 mask
    '{4'd2, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3, 32'hFFFE, 32'hFFFFFFFA, 4'd1},  // R1 signed
    '{4'd2, 1'b0, 2'd0, 1'b1, 1'b0, 32'h00071234, 32'h5, 32'h23, 4'd1},    // R1 hi/lo
    '{4'd2, 1'b0, 2'd0, 1'b1, 1'b1, 32'h80000000, 32'h80000000, 32'h40000000, 4'd1},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h64, 32'h0, 32'h0, 4'd2},
    '{4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3, 32'h4, 32'h0, 4'd2},
    '{4'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h2, 32'h5, 32'h0, 4'd2},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h66, 4'd2},           // R2
    '{4'd0, 1'b0, 2'd1, 1'b0, 1'b0, 32'hFFFF, 32'h3, 32'h0, 4'd3},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h60, 4'd3},           // R3
    '{4'd0, 1'b0, 2'd2, 1'b0, 1'b0, 32'hFFFF, 32'h5, 32'h0, 4'd4},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h5D, 4'd4},           // R4 sign fill
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd8},
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h10, 32'h0, 32'h0, 4'd1},
    '{4'd2, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFFFF, 32'hFFFF, 32'hFFFE0001, 4'd1}, // R1 unsigned
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd4},
    '{4'd0, 1'b0, 2'd2, 1'b0, 1'b0, 32'hFFFF, 32'h3, 32'h0, 4'd4},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h00017FFE, 4'd4},     // R4 zero fill
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h10, 4'd8},
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd6},
    '{4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 32'h00010002, 32'h00030004, 32'h000A0008, 4'd6}, // R6
    '{4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h12345678, 32'hEDCBA988, 4'd6},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd5},
    '{4'd0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h40000000, 32'h2, 32'h0, 4'd5},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h40000000, 4'd5},     // R5 ovf zero fill
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h01, 4'd5},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd5},
    '{4'd0, 1'b1, 2'd2, 1'b0, 1'b0, 32'hFFFFFFFD, 32'h2, 32'h0, 4'd5},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFFD, 4'd5},     // R5 sign fill
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h05, 4'd8},           // R8 sticky V
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h40, 32'h0, 32'h0, 4'd7},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7FFFFFF0, 32'h0, 32'h0, 4'd7},
    '{4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h100, 32'h100, 32'h0, 4'd7},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h7FFFFFFF, 4'd7},     // R7 clamp max
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h41, 4'd8},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h80000005, 32'h0, 32'h0, 4'd7},
    '{4'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h10, 32'h1, 32'h0, 4'd7},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 4'd7},     // R7 clamp min
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd8},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h5, 32'h0, 32'h0, 4'd8},
    '{4'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h5, 32'h1, 32'h0, 4'd8},
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h02, 4'd8},           // R8 zero flag
    '{4'd5, 1'b0, 2'd0, 1'b0, 1'b0, 32'hABCD1234, 32'h0, 32'h0, 4'd9},
    '{4'd8, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1234, 4'd9},         // R9
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h0, 32'h0, 4'd7},
    '{4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h1, 32'h1, 32'h0, 4'd7},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 4'd7},     // R7 wrap
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h05, 4'd8},
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h50, 32'h0, 32'h0, 4'd7},
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFFFFFFF0, 32'h0, 32'h0, 4'd7},
    '{4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 32'hFFFF, 32'hFFFF, 32'h0, 4'd7},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFFF, 4'd7},     // R7 unsigned max
    '{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3, 32'h0, 32'h0, 4'd7},
    '{4'd1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h4, 32'h1, 32'h0, 4'd7},
    '{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd7},            // R7 unsigned zero
    '{4'd7, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h53, 4'd8},
    '{4'd4, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd10}
  };

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_d [128];
  int          exp_r [128];
  int          wr_i = 0, rd_i = 0;

  function automatic logic has_res(logic [3:0] op);
    return (op == 4'd2) || (op == 4'd6) || (op == 4'd7) || (op == 4'd8);
  endfunction

  task automatic chk(input logic ok, input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send(input vec_t v);
    if (has_res(v.op)) begin
      exp_d[wr_i] = v.exp;
      exp_r[wr_i] = int'(v.req);
      wr_i++;
    end
    @(negedge clk);
    op_code = v.op; op_long = v.lng; op_shift = v.sh;
    op_hi_a = v.ha; op_hi_b = v.hb; op_a = v.a; op_b = v.b;
    op_valid = 1'b1;
    while (!op_ready) @(negedge clk);
    @(posedge clk);
    #1 op_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && rd_i != wr_i; k++) @(negedge clk);
  endtask

  // result monitor: results must come back in issue order (R10)
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (rd_i < wr_i) begin
        chk(res_data == exp_d[rd_i], exp_r[rd_i], res_data, exp_d[rd_i]);
        rd_i++;
      end else begin
        chk(1'b0, 10, res_data, 32'h0);
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10: watchdog expired, got %0d results expected %0d", rd_i, wr_i);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state at the ports
    chk(op_ready == 1'b1, 12, {31'b0, op_ready}, 32'h1);
    chk(res_valid == 1'b0, 12, {31'b0, res_valid}, 32'h0);

    for (int i = 0; i < NV; i++) send(VEC[i]);
    drain();

    // R10: result latency of three cycles after the accepting edge
    send('{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 4'd10});
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(res_valid == (k == 4), 10, {31'b0, res_valid}, {31'b0, (k == 4)});
    end
    drain();

    // R6: long op blocks issue for two cycles
    send('{4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 32'h5, 32'h7, 32'h23, 4'd6});
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(op_ready == (k == 3), 6, {31'b0, op_ready}, {31'b0, (k == 3)});
    end
    drain();

    // R11: back-pressure holds result and freezes the pipeline
    @(negedge clk);
    res_ready = 1'b0;
    send('{4'd3, 1'b0, 2'd0, 1'b0, 1'b0, 32'h1111, 32'h0, 32'h0, 4'd11});
    send('{4'd6, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1111, 4'd11});
    send('{4'd8, 1'b0, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h1234, 4'd11});
    repeat (6) @(negedge clk);
    chk(res_valid == 1'b1, 11, {31'b0, res_valid}, 32'h1);
    chk(res_data == 32'h1111, 11, res_data, 32'h1111);
    chk(op_ready == 1'b0, 11, {31'b0, op_ready}, 32'h0);
    held = res_data;
    repeat (3) @(negedge clk);
    chk(res_data == held, 11, res_data, held);
    res_ready = 1'b1;
    drain();
    chk(rd_i == wr_i, 10, rd_i, wr_i);

    summary();
    $finish;
  end
endmodule